// File: doc/BRIEF.md
# Serial CRC-8 Packet Error Checker

This block maintains an 8-bit cyclic redundancy code over a serial bit stream. The code is built one bit at a time, in the same order the bits travel on the wire, with the most significant bit of each byte first. The surrounding serial port does the framing and the SPI timing. It pulses a strobe for every bit that counts and a preset strobe at the start of each command or register group. It also tells the block when the last bit of a group has passed.

The generator polynomial is x^8 + x^2 + x + 1, and the register starts from 0x41. When receiving, the port presents the PEC byte that came after the data and raises the done strobe. One cycle later the block pulses either match or mismatch. When transmitting, the port loads the finished code into a small shifter inside the block. It then steps the shifter so the code goes out most significant bit first, right after the data.

Top module: `pec_serial_engine`

## Requirements
- R1: While reset is asserted and after it is released, crc_o reads 0x41, match_o and mismatch_o are 0, and tx_bit_o is 0.
- R2: An init_i pulse makes crc_o equal 0x41 after the next rising clock edge, whatever the register held before.
- R3: For each clock with bit_vld_i high and init_i low, let f = bit_i XOR crc_o[7]. On the next edge, bit 0 becomes f, bit 1 becomes old bit 0 XOR f, bit 2 becomes old bit 1 XOR f, and bits 7 to 3 take the old bits 6 to 2.
- R4: With bit_vld_i and init_i both low, crc_o holds its value, and bit_i has no effect on it.
- R5: When init_i and bit_vld_i are high in the same cycle, the preset wins and crc_o becomes 0x41.
- R6: Starting from the preset, the single byte 0x01 fed MSB first gives crc_o = 0xC7. After its first bit (a 0), crc_o = 0x82.
- R7: Multi-byte data is absorbed byte by byte, MSB first, and the code is final after the last bit of the last byte. Reordering the bytes changes the result.
- R8: One cycle after done_i, exactly one of match_o and mismatch_o is high for one cycle. match_o is high when crc_o equalled rx_pec_i in the done cycle. Neither is ever high unless done_i was high the cycle before.
- R9: load_tx_i copies crc_o into the transmit shifter, and tx_bit_o then shows its bit 7. Each shift_tx_i cycle moves the next lower bit onto tx_bit_o and fills the bottom with 0. load_tx_i takes priority over shift_tx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Preset the code register to 0x41 |
| bit_vld_i | input | 1 | bit_i is a valid transfer bit this cycle |
| bit_i | input | 1 | Serial data bit, MSB of each byte first |
| done_i | input | 1 | Last bit of the group has passed; compare now |
| rx_pec_i | input | 8 | Received PEC byte for comparison |
| load_tx_i | input | 1 | Copy the current code into the transmit shifter |
| shift_tx_i | input | 1 | Advance the transmit shifter by one bit |
| crc_o | output | 8 | Current code register |
| match_o | output | 1 | One-cycle pulse: received PEC equals computed code |
| mismatch_o | output | 1 | One-cycle pulse: received PEC differs |
| tx_bit_o | output | 1 | Serial code bit to send, MSB first |

## Verification
A wrong tap or a wrong shift in the register shows up on crc_o one clock after the first affected bit. The bench compares crc_o bit by bit against a reference model after every vector. A wrong preset is visible on crc_o immediately after reset or an init pulse. A fault in the compare path shows up as the wrong pulse one cycle after done_i. A fault in the transmit shifter appears within eight shift cycles, when the serial bits stop rebuilding crc_o.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int          PEC_W    = 8;
    localparam logic [7:0]  PEC_POLY = 8'h07;   // x^2 + x + 1 below the implicit x^8
    localparam logic [7:0]  PEC_SEED = 8'h41;

    typedef enum logic [1:0] {
        RES_NONE     = 2'd0,
        RES_MATCH    = 2'd1,
        RES_MISMATCH = 2'd2
    } pec_res_e;
endpackage

// File: rtl/pec_step.sv
// One serial step of the code register: shift up, fold feedback into tapped bits.
module pec_step #(
    parameter int         W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_i,
    input  logic         din_i,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb = din_i ^ crc_i[W-1];

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == 0) begin : g_low
            assign crc_o[k] = POLY[k] & fb;
        end else begin : g_up
            if (POLY[k]) begin : g_tap
                assign crc_o[k] = crc_i[k-1] ^ fb;
            end else begin : g_plain
                assign crc_o[k] = crc_i[k-1];
            end
        end
    end
endmodule

// File: rtl/pec_cmp.sv
// Equality of computed and received code.
module pec_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] calc_i,
    input  logic [W-1:0] rcv_i,
    output logic         equal_o
);
    logic [W-1:0] diff;
    assign diff    = calc_i ^ rcv_i;
    assign equal_o = ~|diff;
endmodule

// File: rtl/pec_tx_shift.sv
// Next value of the transmit shifter; load wins over shift.
module pec_tx_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] sh_q_i,
    input  logic [W-1:0] crc_i,
    input  logic         load_i,
    input  logic         shift_i,
    output logic [W-1:0] sh_d_o
);
    always_comb begin
        if (load_i) begin
            sh_d_o = crc_i;
        end else if (shift_i) begin
            sh_d_o = {sh_q_i[W-2:0], 1'b0};
        end else begin
            sh_d_o = sh_q_i;
        end
    end
endmodule

// File: rtl/pec_serial_engine.sv
module pec_serial_engine
    import pec_pkg::*;
#(
    parameter int           W    = PEC_W,
    parameter logic [W-1:0] POLY = PEC_POLY,
    parameter logic [W-1:0] SEED = PEC_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         bit_vld_i,
    input  logic         bit_i,
    input  logic         done_i,
    input  logic [W-1:0] rx_pec_i,
    input  logic         load_tx_i,
    input  logic         shift_tx_i,
    output logic [W-1:0] crc_o,
    output logic         match_o,
    output logic         mismatch_o,
    output logic         tx_bit_o
);
    typedef struct packed {
        logic [W-1:0] crc;
        logic [W-1:0] tx_sh;
        pec_res_e     res;
    } state_t;

    localparam state_t ST_RESET = '{crc: SEED, tx_sh: '0, res: RES_NONE};

    state_t st_d, st_q;

    logic [W-1:0] crc_step;
    logic         pec_equal;
    logic [W-1:0] tx_next;

    pec_step #(.W(W), .POLY(POLY)) step_i (
        .crc_i (st_q.crc),
        .din_i (bit_i),
        .crc_o (crc_step)
    );

    pec_cmp #(.W(W)) cmp_i (
        .calc_i  (st_q.crc),
        .rcv_i   (rx_pec_i),
        .equal_o (pec_equal)
    );

    pec_tx_shift #(.W(W)) txs_i (
        .sh_q_i  (st_q.tx_sh),
        .crc_i   (st_q.crc),
        .load_i  (load_tx_i),
        .shift_i (shift_tx_i),
        .sh_d_o  (tx_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = RES_NONE;
        if (init_i) begin
            st_d.crc = SEED;
        end else if (bit_vld_i) begin
            st_d.crc = crc_step;
        end
        if (done_i) begin
            st_d.res = pec_equal ? RES_MATCH : RES_MISMATCH;
        end
        st_d.tx_sh = tx_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o      = st_q.crc;
    assign match_o    = (st_q.res == RES_MATCH);
    assign mismatch_o = (st_q.res == RES_MISMATCH);
    assign tx_bit_o   = st_q.tx_sh[W-1];
endmodule

// File: rtl/pec_serial_engine_chk.sv
module pec_serial_engine_chk #(
    parameter int           W    = 8,
    parameter logic [W-1:0] SEED = 8'h41
) (
    input logic         clk,
    input logic         rst_n,
    input logic         init_i,
    input logic         bit_vld_i,
    input logic         bit_i,
    input logic         done_i,
    input logic [W-1:0] rx_pec_i,
    input logic         load_tx_i,
    input logic [W-1:0] crc_o,
    input logic         match_o,
    input logic         mismatch_o,
    input logic         tx_bit_o
);
    AST_INIT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> crc_o == SEED); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !bit_vld_i) |=> $stable(crc_o)); // R4
    AST_STEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && !init_i) |=> crc_o[0] == ($past(bit_i) ^ $past(crc_o[W-1]))); // R3
    AST_STEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && !init_i) |=> crc_o[W-1:3] == $past(crc_o[W-2:2])); // R3
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && mismatch_o)); // R8
    AST_RESULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !match_o && !mismatch_o); // R8
    AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> match_o == ($past(crc_o) == $past(rx_pec_i))); // R8
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx_i |=> tx_bit_o == $past(crc_o[W-1])); // R9
endmodule

bind pec_serial_engine pec_serial_engine_chk #(.W(W), .SEED(SEED)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .done_i     (done_i),
    .rx_pec_i   (rx_pec_i),
    .load_tx_i  (load_tx_i),
    .crc_o      (crc_o),
    .match_o    (match_o),
    .mismatch_o (mismatch_o),
    .tx_bit_o   (tx_bit_o)
);

// File: tb/pec_serial_engine_tb.sv
module pec_serial_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, done_i = 1'b0;
    logic [7:0] rx_pec_i = 8'h00;
    logic       load_tx_i = 1'b0, shift_tx_i = 1'b0;
    logic [7:0] crc_o;
    logic       match_o, mismatch_o, tx_bit_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pec_serial_engine dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .done_i(done_i), .rx_pec_i(rx_pec_i),
        .load_tx_i(load_tx_i), .shift_tx_i(shift_tx_i), .crc_o(crc_o),
        .match_o(match_o), .mismatch_o(mismatch_o), .tx_bit_o(tx_bit_o)
    );

    // Two-byte words fed high byte first, each from a fresh preset.
    localparam logic [15:0] VEC [8] = '{
        16'h0000, 16'h0102, 16'h0201, 16'hFFFF,
        16'hA55A, 16'h8001, 16'h4100, 16'h1234
    };

    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic d);
        logic in0;
        in0 = d ^ c[7];
        return {c[6], c[5], c[4], c[3], c[2], c[1] ^ in0, c[0] ^ in0, in0};
    endfunction

    function automatic logic [7:0] ref_bytes(input logic [15:0] w, input int nb);
        logic [7:0] c;
        c = 8'h41;
        for (int i = nb * 8 - 1; i >= 0; i--) c = ref_step(c, w[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] w, input int nb);
        for (int i = nb * 8 - 1; i >= 0; i--) begin
            bit_vld_i = 1'b1;
            bit_i     = w[i];
            tick();
        end
        bit_vld_i = 1'b0;
    endtask

    task automatic preset();
        init_i = 1'b1;
        tick();
        init_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] exp;
        logic [7:0] got;
        tick();
        // R1 during and after reset
        check("R1 crc in reset", crc_o, 8'h41);
        check("R1 flags in reset", {5'd0, match_o, mismatch_o, tx_bit_o}, 8'h00);
        rst_n = 1'b1;
        tick();
        check("R1 crc after reset", crc_o, 8'h41);

        // R6 single byte 0x01, first-bit intermediate value
        bit_vld_i = 1'b1; bit_i = 1'b0; tick(); bit_vld_i = 1'b0;
        check("R6 after first bit", crc_o, 8'h82);
        send_bits(16'h0001 << 1 >> 1, 0);
        preset();
        send_bits(16'h0001, 1);
        check("R6 byte 0x01", crc_o, 8'hC7);

        // R4 idle hold while bit_i toggles
        for (int i = 0; i < 4; i++) begin bit_i = i[0]; tick(); end
        check("R4 hold", crc_o, 8'hC7);

        // R9 transmit shifter rebuilds the code MSB first
        load_tx_i = 1'b1; tick(); load_tx_i = 1'b0;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], tx_bit_o};
            shift_tx_i = 1'b1; tick();
        end
        shift_tx_i = 1'b0;
        check("R9 serial out", got, 8'hC7);
        check("R9 drained", {7'd0, tx_bit_o}, 8'h00);
        load_tx_i = 1'b1; shift_tx_i = 1'b1; tick();
        load_tx_i = 1'b0; shift_tx_i = 1'b0;
        check("R9 load over shift", {7'd0, tx_bit_o}, 8'h01);

        // R8 compare: match, mismatch, no pulse without done, one-cycle width
        rx_pec_i = 8'hC7; done_i = 1'b1; tick(); done_i = 1'b0;
        check("R8 match", {6'd0, match_o, mismatch_o}, 8'h02);
        tick();
        check("R8 pulse ends", {6'd0, match_o, mismatch_o}, 8'h00);
        rx_pec_i = 8'hC6; done_i = 1'b1; tick(); done_i = 1'b0;
        check("R8 mismatch", {6'd0, match_o, mismatch_o}, 8'h01);

        // R2 preset from a non-seed value
        preset();
        check("R2 preset", crc_o, 8'h41);

        // R5 init with bit_vld together
        send_bits(16'h00F3, 1);
        init_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1; tick();
        init_i = 1'b0; bit_vld_i = 1'b0;
        check("R5 init priority", crc_o, 8'h41);

        // R3 R7 vector table: two bytes MSB first, then compare against PEC
        foreach (VEC[v]) begin
            preset();
            send_bits(VEC[v], 2);
            exp = ref_bytes(VEC[v], 2);
            check("R3 R7 vector crc", crc_o, exp);
            rx_pec_i = v[0] ? (exp ^ 8'h10) : exp;
            done_i = 1'b1; tick(); done_i = 1'b0;
            check("R8 vector result", {6'd0, match_o, mismatch_o},
                  v[0] ? 8'h01 : 8'h02);
        end
        // R7 byte order matters
        check("R7 order differs", {7'd0, ref_bytes(16'h0102, 2) != ref_bytes(16'h0201, 2)}, 8'h01);

        summary();
    end
endmodule